// File: doc/BRIEF.md
# Context-Tagged Direct-Mapped Virtual Data Cache

This block is a write-through data cache that is indexed and tagged with virtual addresses. Each line carries, beside its address tag, the number of the address space (context) that filled it and two protection flags (write-permitted and supervisor) taken from the access that caused the fill. A read hits only when the line is valid, its stored tag equals the upper address field and its stored context equals the context of the current access. A read miss evicts whatever occupies the indexed line and refills the whole line from memory before the processor is released. Writes always go to memory; a write that hits also merges its bytes into the cached line, while a write that misses drops the indexed line instead of allocating it.

Software owns the tag array through a direct tag port: any line's tag word can be written or read back, and a write on that port wins over a processor access presented in the same cycle. After power-up the tag array holds no defined contents, so software clears every tag to invalid before setting the enable input; while the enable input is low, every processor access is passed straight to memory as a single-word transfer. Line count, line size, tag width and context width are parameters; the address is split, from the least significant end, into a byte offset, a line index and a tag, with the bits above the tag ignored.

Top module: `vc_cache`

## Requirements
- R1: While reset is held and in the first cycle after it with no request present, `cpu_ready`, `mem_rd_req` and `mem_wr_req` are all low.
- R2: The tag word seen on `tag_rdata` (and written from `tag_wdata`) places the tag at bits [15:2], the valid flag at bit 19, the supervisor flag at bit 20, the write flag at bit 21 and the context at bits [24:22] (default widths); every other bit reads as zero.
- R3: With `cache_en` low, a read issues exactly one memory read of its word and completes in the cycle the data arrives, a write issues exactly one memory write, and neither changes any tag.
- R4: A read to a valid line whose tag and context match completes in the cycle it is presented, with the cached word and no memory read.
- R5: A read miss fetches the line as four words in ascending address order starting at the line base, then installs the tag with valid=1, the access context and its write/supervisor flags, and returns the requested word; with a memory that answers in the same cycle it completes five cycles after it is presented.
- R6: A read whose context differs from the stored context of a valid line with a matching tag is a miss and refills the line under the new context.
- R7: A write that hits merges only the byte lanes enabled in `cpu_be` into the cached word and issues one memory write with the same word address, data and byte enables; a later read hit returns the merged word.
- R8: A write that misses issues one memory write, clears the valid flag of the indexed line and does not allocate, so a following read to either address refills.
- R9: When `tag_we` is high in the same cycle as a processor access, the tag write takes effect first and the access is not completed or forwarded to memory in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cache_en | input | 1 | Cache enable; low sends every access to memory |
| cpu_rd | input | 1 | Processor read request, held until `cpu_ready` |
| cpu_wr | input | 1 | Processor write request, held until `cpu_ready`; wins over `cpu_rd` |
| cpu_addr | input | 32 | Virtual byte address |
| cpu_ctx | input | 3 | Current context number |
| cpu_wflag | input | 1 | Write-permitted flag recorded on refill |
| cpu_sflag | input | 1 | Supervisor flag recorded on refill |
| cpu_wdata | input | 32 | Write data |
| cpu_be | input | 4 | Byte enables, bit n covers bits [8n+7:8n] |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | Access completes at the next clock edge |
| tag_we | input | 1 | Tag word write strobe |
| tag_idx | input | 6 | Line selected for tag write and tag readback |
| tag_wdata | input | 32 | Tag word to write |
| tag_rdata | output | 32 | Tag word of line `tag_idx` |
| mem_rd_req | output | 1 | Memory word read request |
| mem_rd_addr | output | 32 | Word-aligned read address |
| mem_rd_valid | input | 1 | Read data present this cycle |
| mem_rd_data | input | 32 | Read data from memory |
| mem_wr_req | output | 1 | Memory word write request |
| mem_wr_addr | output | 32 | Word-aligned write address |
| mem_wr_data | output | 32 | Write data to memory |
| mem_wr_be | output | 4 | Byte enables of the memory write |
| mem_wr_ack | input | 1 | Memory accepts the write this cycle |

## Verification
The lookup is exercised with four kinds of read: one to a matching line, one to an invalid line, one whose tag matches but whose context does not, and one presented together with a tag write; counting memory beats and their addresses separates a hit (no beat), a refill (four ascending beats) and a bypass (one beat). Writes are tried against a matching line with a partial byte mask, where a following hit shows whether only the enabled lanes were merged, and against a line holding another tag, where the tag readback and a following refill show invalidation without allocation. An all-ones tag write checks which bits of the tag word are stored.

// File: rtl/vc_pkg.sv
// Package: shared types and tag-word field positions for the virtual cache.
// Assumes a 32-bit tag word with the tag starting two bits above bit 0 and
// three spare bits between the tag and the valid flag.
package vc_pkg;

    typedef enum logic [1:0] {
        VC_IDLE,
        VC_FILL,
        VC_BYPASS,
        VC_WRITE
    } vc_state_e;

    localparam int TID_LSB = 2;

    // Bit position of the valid flag in the tag word for a given tag width.
    function automatic int valid_pos(input int tag_w);
        return TID_LSB + tag_w + 3;
    endfunction

endpackage

// File: rtl/vc_tag_store.sv
// Tag array: one entry per line holding {ctx, wflag, sflag, valid, tid}.
// One write port, two asynchronous read ports (lookup and software readback).
// Assumes software clears every entry before the cache is enabled; the array
// itself has no reset, as a RAM would not.
module vc_tag_store #(
    parameter int INDEX_W = 6,
    parameter int EW      = 20
) (
    input  logic               clk,
    input  logic               we,
    input  logic [INDEX_W-1:0] widx,
    input  logic [EW-1:0]      wentry,
    input  logic [INDEX_W-1:0] lidx,
    output logic [EW-1:0]      lentry,
    input  logic [INDEX_W-1:0] ridx,
    output logic [EW-1:0]      rentry
);
    localparam int LINES = 1 << INDEX_W;

    logic [EW-1:0] tags_q [LINES];

    // Write one tag entry.
    always_ff @(posedge clk) begin
        if (we) begin
            tags_q[widx] <= wentry;
        end
    end

    // Lookup and readback ports.
    always_comb begin
        lentry = tags_q[lidx];
        rentry = tags_q[ridx];
    end

endmodule

// File: rtl/vc_data_store.sv
// Data array: LINES x WORDS words of 32 bits, one RAM per byte lane so that
// byte-enabled writes touch only their lane. Asynchronous read.
module vc_data_store #(
    parameter int INDEX_W = 6,
    parameter int WORD_W  = 2
) (
    input  logic               clk,
    input  logic               we,
    input  logic [INDEX_W-1:0] widx,
    input  logic [WORD_W-1:0]  wword,
    input  logic [3:0]         wbe,
    input  logic [31:0]        wdata,
    input  logic [INDEX_W-1:0] ridx,
    input  logic [WORD_W-1:0]  rword,
    output logic [31:0]        rdata
);
    localparam int DEPTH = 1 << (INDEX_W + WORD_W);

    logic [INDEX_W+WORD_W-1:0] waddr;
    logic [INDEX_W+WORD_W-1:0] raddr;

    // Flatten line and word into a RAM address.
    always_comb begin
        waddr = {widx, wword};
        raddr = {ridx, rword};
    end

    for (genvar b = 0; b < 4; b++) begin : g_lane
        logic [7:0] lane_q [DEPTH];

        // Write this byte lane when its enable is set.
        always_ff @(posedge clk) begin
            if (we && wbe[b]) begin
                lane_q[waddr] <= wdata[8*b +: 8];
            end
        end

        // Read this byte lane.
        always_comb begin
            rdata[8*b +: 8] = lane_q[raddr];
        end
    end

endmodule

// File: rtl/vc_ctrl.sv
// Access controller: accepts one processor access at a time, decides between
// hit, refill, bypass and write-through, sequences the line refill and drives
// the memory ports. Assumes the processor holds its request stable until
// cpu_ready and that tag_we blocks acceptance in the same cycle.
module vc_ctrl #(
    parameter int ADDR_W   = 32,
    parameter int OFFSET_W = 4,
    parameter int CTX_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_rd,
    input  logic                cpu_wr,
    input  logic [ADDR_W-1:2]   cpu_waddr,
    input  logic [31:0]         cpu_wdata,
    input  logic [3:0]          cpu_be,
    input  logic [CTX_W-1:0]    cpu_ctx,
    input  logic                cpu_wflag,
    input  logic                cpu_sflag,
    input  logic                cache_en,
    input  logic                hit,
    input  logic                tag_we,
    input  logic                mem_rd_valid,
    input  logic                mem_wr_ack,
    output logic                cpu_ready,
    output logic                rdata_from_mem,
    output logic                mem_rd_req,
    output logic [ADDR_W-1:0]   mem_rd_addr,
    output logic                mem_wr_req,
    output logic [ADDR_W-1:0]   mem_wr_addr,
    output logic [31:0]         mem_wr_data,
    output logic [3:0]          mem_wr_be,
    output logic                fill_we,
    output logic [OFFSET_W-3:0] fill_word,
    output logic                fill_done,
    output logic [ADDR_W-1:2]   lat_waddr,
    output logic [CTX_W-1:0]    lat_ctx,
    output logic                lat_wflag,
    output logic                lat_sflag,
    output logic                upd_we,
    output logic                inv_we
);
    import vc_pkg::*;

    localparam int WORD_W = OFFSET_W - 2;

    vc_state_e            st_q;
    logic [WORD_W-1:0]    cnt_q;
    logic [31:0]          lat_wdata;
    logic [3:0]           lat_be;
    logic                 accept;
    logic                 read_hit;
    logic                 last_beat;

    // Acceptance and the hit/miss actions taken in the accepting cycle.
    always_comb begin
        accept   = (st_q == VC_IDLE) && !tag_we && (cpu_rd || cpu_wr);
        upd_we   = accept && cpu_wr && cache_en && hit;
        inv_we   = accept && cpu_wr && cache_en && !hit;
        read_hit = accept && !cpu_wr && cache_en && hit;
        last_beat = (cnt_q == {WORD_W{1'b1}});
    end

    // State, refill counter and latched access fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= VC_IDLE;
            cnt_q     <= '0;
            lat_waddr <= '0;
            lat_wdata <= '0;
            lat_be    <= '0;
            lat_ctx   <= '0;
            lat_wflag <= 1'b0;
            lat_sflag <= 1'b0;
        end else begin
            unique case (st_q)
                VC_IDLE: begin
                    if (accept) begin
                        lat_waddr <= cpu_waddr;
                        lat_wdata <= cpu_wdata;
                        lat_be    <= cpu_be;
                        lat_ctx   <= cpu_ctx;
                        lat_wflag <= cpu_wflag;
                        lat_sflag <= cpu_sflag;
                        cnt_q     <= '0;
                        if (cpu_wr) begin
                            st_q <= VC_WRITE;
                        end else if (!cache_en) begin
                            st_q <= VC_BYPASS;
                        end else if (!hit) begin
                            st_q <= VC_FILL;
                        end
                    end
                end
                VC_FILL: begin
                    if (mem_rd_valid) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (last_beat) begin
                            st_q <= VC_IDLE;
                        end
                    end
                end
                VC_BYPASS: begin
                    if (mem_rd_valid) begin
                        st_q <= VC_IDLE;
                    end
                end
                VC_WRITE: begin
                    if (mem_wr_ack) begin
                        st_q <= VC_IDLE;
                    end
                end
                default: st_q <= VC_IDLE;
            endcase
        end
    end

    // Memory port requests and addresses.
    always_comb begin
        mem_rd_req  = (st_q == VC_FILL) || (st_q == VC_BYPASS);
        mem_rd_addr = (st_q == VC_FILL)
                    ? {lat_waddr[ADDR_W-1:OFFSET_W], cnt_q, 2'b00}
                    : {lat_waddr, 2'b00};
        mem_wr_req  = (st_q == VC_WRITE);
        mem_wr_addr = {lat_waddr, 2'b00};
        mem_wr_data = lat_wdata;
        mem_wr_be   = lat_be;
    end

    // Refill array controls and processor completion.
    always_comb begin
        fill_we        = (st_q == VC_FILL) && mem_rd_valid;
        fill_word      = cnt_q;
        fill_done      = fill_we && last_beat;
        rdata_from_mem = (st_q == VC_BYPASS);
        cpu_ready      = read_hit
                       || ((st_q == VC_BYPASS) && mem_rd_valid)
                       || ((st_q == VC_WRITE) && mem_wr_ack);
    end

endmodule

// File: rtl/vc_cache.sv
// Top: context-tagged direct-mapped virtual write-through data cache.
// Splits the address, compares tag and context, arbitrates the single tag
// write port (software > refill install > write-miss invalidate) and the
// data write port (refill > write hit), and packs the software tag word.
// Assumes OFFSET_W >= 3 and that the tag word fields fit in 32 bits.
module vc_cache #(
    parameter int INDEX_W  = 6,
    parameter int OFFSET_W = 4,
    parameter int TAG_W    = 14,
    parameter int CTX_W    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cache_en,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  logic [31:0]        cpu_addr,
    input  logic [CTX_W-1:0]   cpu_ctx,
    input  logic               cpu_wflag,
    input  logic               cpu_sflag,
    input  logic [31:0]        cpu_wdata,
    input  logic [3:0]         cpu_be,
    output logic [31:0]        cpu_rdata,
    output logic               cpu_ready,
    input  logic               tag_we,
    input  logic [INDEX_W-1:0] tag_idx,
    input  logic [31:0]        tag_wdata,
    output logic [31:0]        tag_rdata,
    output logic               mem_rd_req,
    output logic [31:0]        mem_rd_addr,
    input  logic               mem_rd_valid,
    input  logic [31:0]        mem_rd_data,
    output logic               mem_wr_req,
    output logic [31:0]        mem_wr_addr,
    output logic [31:0]        mem_wr_data,
    output logic [3:0]         mem_wr_be,
    input  logic               mem_wr_ack
);
    localparam int WORD_W  = OFFSET_W - 2;
    localparam int TAG_LSB = OFFSET_W + INDEX_W;
    localparam int TID_LSB = vc_pkg::TID_LSB;
    localparam int V_POS   = vc_pkg::valid_pos(TAG_W);
    localparam int S_POS   = V_POS + 1;
    localparam int W_POS   = V_POS + 2;
    localparam int CTX_LSB = V_POS + 3;
    localparam int EW      = CTX_W + 3 + TAG_W;
    localparam logic [31:0] FIELD_MASK =
          ((32'(1) << CTX_W) - 32'(1)) << CTX_LSB
        | (32'(7) << V_POS)
        | ((32'(1) << TAG_W) - 32'(1)) << TID_LSB;

    // Entry layout inside the tag store: {ctx, wflag, sflag, valid, tid}.
    localparam int E_V = TAG_W;

    logic [TAG_W-1:0]   a_tag;
    logic [INDEX_W-1:0] a_idx;
    logic [WORD_W-1:0]  a_word;
    logic [EW-1:0]      look_e;
    logic [EW-1:0]      read_e;
    logic               hit;

    logic               twe;
    logic [INDEX_W-1:0] twidx;
    logic [EW-1:0]      twentry;

    logic               dwe;
    logic [INDEX_W-1:0] dwidx;
    logic [WORD_W-1:0]  dwword;
    logic [3:0]         dwbe;
    logic [31:0]        dwdata;
    logic [31:0]        array_rdata;

    logic               rdata_from_mem;
    logic               fill_we;
    logic [WORD_W-1:0]  fill_word;
    logic               fill_done;
    logic [31:2]        lat_waddr;
    logic [CTX_W-1:0]   lat_ctx;
    logic               lat_wflag;
    logic               lat_sflag;
    logic               upd_we;
    logic               inv_we;

    logic [31:0]        unused_tag_bits;
    logic [31:0]        unused_addr_bits;

    // Address split and hit compare (valid, tag and context must all match).
    always_comb begin
        a_tag  = cpu_addr[TAG_LSB +: TAG_W];
        a_idx  = cpu_addr[OFFSET_W +: INDEX_W];
        a_word = cpu_addr[2 +: WORD_W];
        hit    = look_e[E_V]
              && (look_e[TAG_W-1:0] == a_tag)
              && (look_e[EW-1 -: CTX_W] == cpu_ctx);
    end

    // Tag write port arbitration: software first, then refill install, then invalidate.
    always_comb begin
        twe     = tag_we || fill_done || inv_we;
        twidx   = a_idx;
        twentry = look_e & ~(EW'(1) << E_V);
        if (tag_we) begin
            twidx   = tag_idx;
            twentry = {tag_wdata[CTX_LSB +: CTX_W], tag_wdata[W_POS], tag_wdata[S_POS],
                       tag_wdata[V_POS], tag_wdata[TID_LSB +: TAG_W]};
        end else if (fill_done) begin
            twidx   = lat_waddr[OFFSET_W +: INDEX_W];
            twentry = {lat_ctx, lat_wflag, lat_sflag, 1'b1, lat_waddr[TAG_LSB +: TAG_W]};
        end
    end

    // Data write port: refill beats or write-hit byte merge.
    always_comb begin
        dwe    = fill_we || upd_we;
        dwidx  = a_idx;
        dwword = a_word;
        dwbe   = cpu_be;
        dwdata = cpu_wdata;
        if (fill_we) begin
            dwidx  = lat_waddr[OFFSET_W +: INDEX_W];
            dwword = fill_word;
            dwbe   = 4'hF;
            dwdata = mem_rd_data;
        end
    end

    // Software tag readback packing; bits outside the fields read as zero.
    always_comb begin
        tag_rdata = '0;
        tag_rdata[TID_LSB +: TAG_W] = read_e[TAG_W-1:0];
        tag_rdata[V_POS]            = read_e[E_V];
        tag_rdata[S_POS]            = read_e[E_V+1];
        tag_rdata[W_POS]            = read_e[E_V+2];
        tag_rdata[CTX_LSB +: CTX_W] = read_e[EW-1 -: CTX_W];
        cpu_rdata = rdata_from_mem ? mem_rd_data : array_rdata;
        unused_tag_bits  = tag_wdata & ~FIELD_MASK;
        unused_addr_bits = {cpu_addr[1:0], 30'(cpu_addr >> (TAG_LSB + TAG_W))};
    end

    vc_tag_store #(
        .INDEX_W (INDEX_W),
        .EW      (EW)
    ) u_tags (
        .clk    (clk),
        .we     (twe),
        .widx   (twidx),
        .wentry (twentry),
        .lidx   (a_idx),
        .lentry (look_e),
        .ridx   (tag_idx),
        .rentry (read_e)
    );

    vc_data_store #(
        .INDEX_W (INDEX_W),
        .WORD_W  (WORD_W)
    ) u_data (
        .clk   (clk),
        .we    (dwe),
        .widx  (dwidx),
        .wword (dwword),
        .wbe   (dwbe),
        .wdata (dwdata),
        .ridx  (a_idx),
        .rword (a_word),
        .rdata (array_rdata)
    );

    vc_ctrl #(
        .ADDR_W   (32),
        .OFFSET_W (OFFSET_W),
        .CTX_W    (CTX_W)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpu_rd         (cpu_rd),
        .cpu_wr         (cpu_wr),
        .cpu_waddr      (cpu_addr[31:2]),
        .cpu_wdata      (cpu_wdata),
        .cpu_be         (cpu_be),
        .cpu_ctx        (cpu_ctx),
        .cpu_wflag      (cpu_wflag),
        .cpu_sflag      (cpu_sflag),
        .cache_en       (cache_en),
        .hit            (hit),
        .tag_we         (tag_we),
        .mem_rd_valid   (mem_rd_valid),
        .mem_wr_ack     (mem_wr_ack),
        .cpu_ready      (cpu_ready),
        .rdata_from_mem (rdata_from_mem),
        .mem_rd_req     (mem_rd_req),
        .mem_rd_addr    (mem_rd_addr),
        .mem_wr_req     (mem_wr_req),
        .mem_wr_addr    (mem_wr_addr),
        .mem_wr_data    (mem_wr_data),
        .mem_wr_be      (mem_wr_be),
        .fill_we        (fill_we),
        .fill_word      (fill_word),
        .fill_done      (fill_done),
        .lat_waddr      (lat_waddr),
        .lat_ctx        (lat_ctx),
        .lat_wflag      (lat_wflag),
        .lat_sflag      (lat_sflag),
        .upd_we         (upd_we),
        .inv_we         (inv_we)
    );

endmodule

// File: rtl/vc_cache_chk.sv
// Checker for vc_cache: port-level protocol and ordering properties.
// Bound to every vc_cache instance by the bind statement at the end.
module vc_cache_chk #(
    parameter int INDEX_W  = 6,
    parameter int OFFSET_W = 4,
    parameter int TAG_W    = 14,
    parameter int CTX_W    = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cache_en,
    input logic        cpu_rd,
    input logic        cpu_wr,
    input logic [31:0] cpu_addr,
    input logic [31:0] cpu_wdata,
    input logic        cpu_ready,
    input logic        tag_we,
    input logic [31:0] tag_rdata,
    input logic        mem_rd_req,
    input logic [31:0] mem_rd_addr,
    input logic        mem_rd_valid,
    input logic        mem_wr_req,
    input logic [31:0] mem_wr_addr,
    input logic [31:0] mem_wr_data,
    input logic        mem_wr_ack
);
    localparam int V_POS   = vc_pkg::valid_pos(TAG_W);
    localparam int CTX_LSB = V_POS + 3;
    localparam logic [31:0] FIELD_MASK =
          ((32'(1) << CTX_W) - 32'(1)) << CTX_LSB
        | (32'(7) << V_POS)
        | ((32'(1) << TAG_W) - 32'(1)) << vc_pkg::TID_LSB;

    logic unused_idx;
    assign unused_idx = (INDEX_W > 0);

    // R2: only the defined tag-word fields can ever read as one.
    assert_tag_spare_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_rdata & ~FIELD_MASK) == 32'h0);

    // R3: with the cache off, a read can only complete alongside its memory read.
    assert_bypass_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cache_en && cpu_rd && !cpu_wr && cpu_ready) |-> (mem_rd_req && mem_rd_valid));

    // R4: a read completing without a memory read must come from an enabled cache.
    assert_hit_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_rd && !cpu_wr && !mem_rd_req) |-> cache_en);

    // R5: consecutive refill beats step through the line in ascending words.
    assert_fill_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_rd_req && mem_rd_valid) && mem_rd_req
         && ($past(mem_rd_addr[OFFSET_W-1:2]) != {(OFFSET_W-2){1'b1}}))
        |-> (mem_rd_addr == $past(mem_rd_addr) + 32'd4));

    // R7: every completed write is carried to memory with its address and data.
    assert_write_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_ready) |-> (mem_wr_req && mem_wr_ack
            && mem_wr_addr[31:2] == cpu_addr[31:2] && mem_wr_data == cpu_wdata));

    // R9: a tag write in an idle cycle holds off processor completion.
    assert_tag_write_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_we && !mem_rd_req && !mem_wr_req) |-> !cpu_ready);

endmodule

bind vc_cache vc_cache_chk #(
    .INDEX_W  (INDEX_W),
    .OFFSET_W (OFFSET_W),
    .TAG_W    (TAG_W),
    .CTX_W    (CTX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cache_en     (cache_en),
    .cpu_rd       (cpu_rd),
    .cpu_wr       (cpu_wr),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .cpu_ready    (cpu_ready),
    .tag_we       (tag_we),
    .tag_rdata    (tag_rdata),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_wr_req   (mem_wr_req),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .mem_wr_ack   (mem_wr_ack)
);

// File: tb/vc_cache_tb.sv
`timescale 1ns/1ps
// Directed bench for vc_cache: one task per scenario, memory model that
// answers in the same cycle, and a reference copy of memory contents.
module vc_cache_tb;
    localparam int IDX_W  = 6;
    localparam int LINES  = 1 << IDX_W;
    localparam int MWORDS = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cache_en = 1'b0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [2:0]  cpu_ctx = '0;
    logic        cpu_wflag = 1'b0;
    logic        cpu_sflag = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_ready;
    logic        tag_we = 1'b0;
    logic [IDX_W-1:0] tag_idx = '0;
    logic [31:0] tag_wdata = '0;
    logic [31:0] tag_rdata;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_data;
    logic        mem_wr_req;
    logic [31:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic [3:0]  mem_wr_be;
    logic        mem_wr_ack;

    logic [31:0] bmem    [MWORDS];
    logic [31:0] ref_mem [MWORDS];
    logic [31:0] beat_addr [8];
    int          rd_beats = 0;
    int          wr_beats = 0;
    logic [31:0] last_wa, last_wd;
    logic [3:0]  last_wbe;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    vc_cache u_dut (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_ctx(cpu_ctx),
        .cpu_wflag(cpu_wflag), .cpu_sflag(cpu_sflag), .cpu_wdata(cpu_wdata),
        .cpu_be(cpu_be), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .tag_we(tag_we), .tag_idx(tag_idx), .tag_wdata(tag_wdata), .tag_rdata(tag_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be), .mem_wr_ack(mem_wr_ack)
    );

    // Same-cycle memory model.
    assign mem_rd_valid = mem_rd_req;
    assign mem_rd_data  = bmem[mem_rd_addr[11:2]];
    assign mem_wr_ack   = mem_wr_req;

    always @(posedge clk) begin
        if (rst_n && mem_rd_req && mem_rd_valid) begin
            beat_addr[rd_beats % 8] <= mem_rd_addr;
            rd_beats <= rd_beats + 1;
        end
        if (rst_n && mem_wr_req && mem_wr_ack) begin
            for (int b = 0; b < 4; b++)
                if (mem_wr_be[b]) bmem[mem_wr_addr[11:2]][8*b +: 8] <= mem_wr_data[8*b +: 8];
            wr_beats <= wr_beats + 1;
            last_wa  <= mem_wr_addr;
            last_wd  <= mem_wr_data;
            last_wbe <= mem_wr_be;
        end
    end

    function automatic logic [31:0] mk_addr(input int tag, input int idx, input int word);
        return 32'((tag << 10) | (idx << 4) | (word << 2));
    endfunction

    function automatic logic [31:0] tag_word(input int ctx, input bit w, input bit s,
                                             input bit v, input int tid);
        return 32'((ctx << 22) | (int'(w) << 21) | (int'(s) << 20) | (int'(v) << 19) | (tid << 2));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [31:0] addr, input logic [2:0] ctx,
                          input bit wf, input bit sf, input logic [31:0] wd,
                          input logic [3:0] be, output logic [31:0] rd,
                          output int rbeats, output int wbeats, output int cyc);
        int b0, w0;
        @(negedge clk);
        cpu_rd = !wr; cpu_wr = wr; cpu_addr = addr; cpu_ctx = ctx;
        cpu_wflag = wf; cpu_sflag = sf; cpu_wdata = wd; cpu_be = be;
        b0 = rd_beats; w0 = wr_beats; cyc = 0;
        #1;
        while (!cpu_ready && cyc < 50) begin
            @(negedge clk); #1; cyc++;
        end
        rd = cpu_rdata;
        if (wr)
            for (int b = 0; b < 4; b++)
                if (be[b]) ref_mem[addr[11:2]][8*b +: 8] = wd[8*b +: 8];
        @(posedge clk); #1;
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        rbeats = rd_beats - b0; wbeats = wr_beats - w0;
    endtask

    task automatic tag_write(input int idx, input logic [31:0] w);
        @(negedge clk);
        tag_we = 1'b1; tag_idx = IDX_W'(idx); tag_wdata = w;
        @(posedge clk); #1;
        tag_we = 1'b0;
    endtask

    task automatic tag_read(input int idx, output logic [31:0] w);
        @(negedge clk);
        tag_idx = IDX_W'(idx);
        #1 w = tag_rdata;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 ready in reset", 32'(cpu_ready), 32'd0);
        chk("R1 rd_req in reset", 32'(mem_rd_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", 32'(cpu_ready), 32'd0);
        chk("R1 wr_req after reset", 32'(mem_wr_req), 32'd0);
    endtask

    task automatic t_clear_tags;
        logic [31:0] w;
        for (int i = 0; i < LINES; i++) tag_write(i, 32'h0);
        tag_read(LINES - 1, w);
        chk("R2 cleared tag", w, 32'h0);
    endtask

    task automatic t_tag_layout;
        logic [31:0] w;
        tag_write(5, 32'hFFFF_FFFF);
        tag_read(5, w);
        chk("R2 all-ones tag readback", w, 32'h01F8_FFFC);
        tag_write(5, tag_word(6, 1'b0, 1'b1, 1'b0, 16'h2A5));
        tag_read(5, w);
        chk("R2 field tag readback", w, tag_word(6, 1'b0, 1'b1, 1'b0, 16'h2A5));
        tag_write(5, 32'h0);
    endtask

    task automatic t_bypass;
        logic [31:0] rd, w;
        int rb, wb, cyc;
        cache_en = 1'b0;
        access(1'b0, mk_addr(0, 9, 1), 3'd1, 1'b0, 1'b0, '0, '0, rd, rb, wb, cyc);
        chk("R3 bypass read data", rd, ref_mem[mk_addr(0, 9, 1) >> 2]);
        chk("R3 bypass read beats", 32'(rb), 32'd1);
        access(1'b1, mk_addr(0, 9, 2), 3'd1, 1'b0, 1'b0, 32'h1357_9BDF, 4'hF, rd, rb, wb, cyc);
        chk("R3 bypass write beats", 32'(wb), 32'd1);
        chk("R3 bypass write addr", last_wa, mk_addr(0, 9, 2));
        tag_read(9, w);
        chk("R3 tag untouched", w, 32'h0);
    endtask

    task automatic t_read_miss;
        logic [31:0] rd, w;
        int rb, wb, cyc;
        access(1'b0, mk_addr(0, 3, 2), 3'd1, 1'b1, 1'b0, '0, '0, rd, rb, wb, cyc);
        chk("R5 refill beats", 32'(rb), 32'd4);
        for (int k = 0; k < 4; k++)
            chk("R5 refill order", beat_addr[(rd_beats - 4 + k) % 8], mk_addr(0, 3, k));
        chk("R5 refill data", rd, ref_mem[mk_addr(0, 3, 2) >> 2]);
        chk("R5 refill latency", 32'(cyc), 32'd5);
        tag_read(3, w);
        chk("R5 installed tag", w, tag_word(1, 1'b1, 1'b0, 1'b1, 0));
    endtask

    task automatic t_read_hit;
        logic [31:0] rd;
        int rb, wb, cyc;
        access(1'b0, mk_addr(0, 3, 0), 3'd1, 1'b0, 1'b0, '0, '0, rd, rb, wb, cyc);
        chk("R4 hit data", rd, ref_mem[mk_addr(0, 3, 0) >> 2]);
        chk("R4 hit beats", 32'(rb), 32'd0);
        chk("R4 hit latency", 32'(cyc), 32'd0);
    endtask

    task automatic t_ctx_mismatch;
        logic [31:0] rd, w;
        int rb, wb, cyc;
        access(1'b0, mk_addr(0, 3, 3), 3'd2, 1'b0, 1'b1, '0, '0, rd, rb, wb, cyc);
        chk("R6 other context refills", 32'(rb), 32'd4);
        chk("R6 data", rd, ref_mem[mk_addr(0, 3, 3) >> 2]);
        tag_read(3, w);
        chk("R6 new context installed", w, tag_word(2, 1'b0, 1'b1, 1'b1, 0));
    endtask

    task automatic t_write_hit;
        logic [31:0] rd, expw;
        int rb, wb, cyc;
        expw = ref_mem[mk_addr(0, 3, 1) >> 2];
        expw[7:0] = 8'hAA; expw[23:16] = 8'hCC;
        access(1'b1, mk_addr(0, 3, 1), 3'd2, 1'b0, 1'b0, 32'hDDCC_BBAA, 4'b0101, rd, rb, wb, cyc);
        chk("R7 one memory write", 32'(wb), 32'd1);
        chk("R7 write addr", last_wa, mk_addr(0, 3, 1));
        chk("R7 write be", 32'(last_wbe), 32'h5);
        chk("R7 write data", last_wd, 32'hDDCC_BBAA);
        access(1'b0, mk_addr(0, 3, 1), 3'd2, 1'b0, 1'b0, '0, '0, rd, rb, wb, cyc);
        chk("R7 merged hit data", rd, expw);
        chk("R7 merged hit no refill", 32'(rb), 32'd0);
    endtask

    task automatic t_write_miss;
        logic [31:0] rd, w;
        int rb, wb, cyc;
        access(1'b1, mk_addr(1, 3, 0), 3'd2, 1'b0, 1'b0, 32'h0BAD_F00D, 4'hF, rd, rb, wb, cyc);
        chk("R8 memory write", 32'(wb), 32'd1);
        tag_read(3, w);
        chk("R8 valid cleared", 32'(w[19]), 32'd0);
        access(1'b0, mk_addr(1, 3, 0), 3'd2, 1'b0, 1'b0, '0, '0, rd, rb, wb, cyc);
        chk("R8 no allocate", 32'(rb), 32'd4);
        chk("R8 written data via refill", rd, 32'h0BAD_F00D);
        access(1'b0, mk_addr(0, 3, 1), 3'd2, 1'b0, 1'b0, '0, '0, rd, rb, wb, cyc);
        chk("R8 old line gone", 32'(rb), 32'd4);
        chk("R8 old line data", rd, ref_mem[mk_addr(0, 3, 1) >> 2]);
    endtask

    task automatic t_priority;
        int b0, cyc;
        b0 = rd_beats;
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = mk_addr(0, 3, 2); cpu_ctx = 3'd2;
        tag_we = 1'b1; tag_idx = IDX_W'(3); tag_wdata = 32'h0;
        #1;
        chk("R9 held off", 32'(cpu_ready), 32'd0);
        chk("R9 no memory read", 32'(mem_rd_req), 32'd0);
        @(posedge clk); #1;
        tag_we = 1'b0;
        cyc = 0;
        while (!cpu_ready && cyc < 50) begin
            @(negedge clk); #1; cyc++;
        end
        chk("R9 data after tag write", cpu_rdata, ref_mem[mk_addr(0, 3, 2) >> 2]);
        @(posedge clk); #1;
        cpu_rd = 1'b0;
        chk("R9 tag write applied first", 32'(rd_beats - b0), 32'd4);
    endtask

    initial begin
        for (int i = 0; i < MWORDS; i++) begin
            bmem[i]    = {16'hC0DE ^ 16'(i * 7), 16'(i)};
            ref_mem[i] = {16'hC0DE ^ 16'(i * 7), 16'(i)};
        end
        repeat (3) @(posedge clk);
        t_reset;
        t_clear_tags;
        t_tag_layout;
        t_bypass;
        cache_en = 1'b1;
        t_read_miss;
        t_read_hit;
        t_ctx_mismatch;
        t_write_hit;
        t_write_miss;
        t_priority;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule